// File: doc/BRIEF.md
# Bidirectional LED Chaser Controller

The block walks a single lit position across a row of LEDs. While an enable switch is on, an internal prescaler divides the system clock down to a once-per-second tick, and each tick moves the lit position one place in the current direction, wrapping at both ends. The direction can be flipped at runtime either by a pushbutton pulse or by a command from a host processor.

The host talks to the block through a one-cycle command port. It can read the current position, load a new position, or request a reversal. The block also counts how many steps have been made since the latest reversal. A second pushbutton sends that count to the host. Every answer to the host is a 32-bit code followed by a 32-bit value, both qualified by a one-cycle valid strobe. Button debouncing and the transport between processors are handled outside the block.

Top module: `led_chaser_top`

## Requirements
- R1: After reset the position is 0 (LED output 0x01), the direction is upward, the step count is 0 and respValid is low.
- R2: With CLK_HZ clock cycles per tick, the position moves exactly once every CLK_HZ cycles while enSwitch is high, and never while it is low. The prescaler restarts from zero whenever enSwitch is low.
- R3: An upward step from index NUM_LEDS-1 goes to 0. A downward step from 0 goes to NUM_LEDS-1.
- R4: ledOut always has exactly one bit set, and that bit is the one at the current position.
- R5: A revBtn pulse, or a host command with hostOp = 2 (reverse), flips the direction.
- R6: When a reversal request and a tick fall in the same cycle, the step uses the new direction.
- R7: A host command with hostOp = 1 (write) loads hostPos as the new position when hostPos < NUM_LEDS. A larger value is ignored. A write never changes the step count. A write takes priority over a tick in the same cycle.
- R8: A host command with hostOp = 0 (read) raises respValid for exactly one cycle, starting the cycle after the command, with respCode = 1 and respData = the position held when the command was issued.
- R9: The step count rises by one on every tick step. A reversal resets it to 0, or to 1 if a step happens in the same cycle.
- R10: A reportBtn pulse gives a one-cycle response with respCode = 2 and respData = the step count. If a host read arrives in the same cycle, the position report wins and the count report is dropped.
- R11: A command with hostOp = 3 changes nothing and produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| enSwitch | input | 1 | Stepping enable |
| revBtn | input | 1 | Debounced one-cycle reverse pulse |
| reportBtn | input | 1 | Debounced one-cycle count-report pulse |
| hostValid | input | 1 | Host command valid for one cycle |
| hostOp | input | 2 | 0 read, 1 write, 2 reverse, 3 no operation |
| hostPos | input | 32 | Position for a write command |
| ledOut | output | NUM_LEDS | One-hot LED drive |
| respValid | output | 1 | One-cycle response strobe |
| respCode | output | 32 | 1 position report, 2 count report |
| respData | output | 32 | Reported value |

## Verification
The assertions assume that the button inputs and hostValid are pulses of one cycle and that the host sends at most one command per cycle. The bench keeps to this by asserting each for a single cycle from a task. It also assumes that the stepping stays predictable. For that reason the bench issues host commands only while the switch is off, so the prescaler sits at zero. The one exception is the collision scenario, where a reversal pulse is placed on the exact cycle of a tick.

// File: rtl/led_chaser_pkg.sv
package led_chaser_pkg;
  localparam logic [1:0] OP_READ  = 2'd0;
  localparam logic [1:0] OP_WRITE = 2'd1;
  localparam logic [1:0] OP_REV   = 2'd2;
  localparam logic [31:0] RESP_POS = 32'h0000_0001;
  localparam logic [31:0] RESP_CNT = 32'h0000_0002;

  typedef struct packed {
    logic tick;
    logic flipDir;
    logic load;
    logic reportPos;
    logic reportCnt;
  } chaserStrobes_t;
endpackage

// File: rtl/led_chaser_ctrl.sv
module led_chaser_ctrl
  import led_chaser_pkg::*;
#(
  parameter int NUM_LEDS = 8,
  parameter int CLK_HZ   = 50_000_000
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           enSwitch,
  input  logic           revBtn,
  input  logic           reportBtn,
  input  logic           hostValid,
  input  logic [1:0]     hostOp,
  input  logic [31:0]    hostPos,
  output chaserStrobes_t strobes
);
  localparam int PRE_W = (CLK_HZ > 1) ? $clog2(CLK_HZ) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_HZ - 1);

  logic [PRE_W-1:0] preCnt;
  logic             preWrap;

  assign preWrap = enSwitch && (preCnt == PRE_LAST);

  always_ff @(posedge clk) begin
    if (!rstN || !enSwitch || preWrap) preCnt <= '0;
    else                               preCnt <= preCnt + 1'b1;
  end

  always_comb begin
    strobes.tick      = preWrap;
    strobes.flipDir   = revBtn || (hostValid && hostOp == OP_REV);
    strobes.load      = hostValid && hostOp == OP_WRITE && hostPos < 32'(NUM_LEDS);
    strobes.reportPos = hostValid && hostOp == OP_READ;
    strobes.reportCnt = reportBtn;
  end

  p_prescale_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    !enSwitch |=> preCnt == '0);
  p_tick_only_enabled_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.tick |-> $past(enSwitch) || $past(preCnt) == PRE_LAST - 1'b1);
endmodule

// File: rtl/led_chaser_datapath.sv
module led_chaser_datapath
  import led_chaser_pkg::*;
#(
  parameter int NUM_LEDS = 8,
  parameter int CNT_W    = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  chaserStrobes_t              strobes,
  input  logic [$clog2(NUM_LEDS)-1:0] loadPos,
  output logic [NUM_LEDS-1:0]         ledOut,
  output logic                        respValid,
  output logic [31:0]                 respCode,
  output logic [31:0]                 respData
);
  localparam int POS_W = $clog2(NUM_LEDS);
  localparam logic [POS_W-1:0] POS_MAX = POS_W'(NUM_LEDS - 1);

  logic [POS_W-1:0] pos, stepPos;
  logic             dirUp, dirNext;
  logic [CNT_W-1:0] stepCnt;

  assign dirNext = dirUp ^ strobes.flipDir;

  always_comb begin
    if (dirNext) stepPos = (pos == POS_MAX) ? '0 : pos + 1'b1;
    else         stepPos = (pos == '0) ? POS_MAX : pos - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pos     <= '0;
      dirUp   <= 1'b1;
      stepCnt <= '0;
    end else begin
      dirUp <= dirNext;
      if (strobes.load) pos <= loadPos;
      else if (strobes.tick) pos <= stepPos;
      if (strobes.tick && !strobes.load)
        stepCnt <= strobes.flipDir ? CNT_W'(1) : stepCnt + 1'b1;
      else if (strobes.flipDir)
        stepCnt <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respCode  <= '0;
      respData  <= '0;
    end else begin
      respValid <= strobes.reportPos || strobes.reportCnt;
      if (strobes.reportPos) begin
        respCode <= RESP_POS;
        respData <= 32'(pos);
      end else if (strobes.reportCnt) begin
        respCode <= RESP_CNT;
        respData <= 32'(stepCnt);
      end
    end
  end

  always_comb begin
    ledOut = '0;
    ledOut[pos] = 1'b1;
  end

  p_led_onehot_r4: assert property (@(posedge clk) disable iff (!rstN)
    $countones(ledOut) == 1);
  p_hold_pos_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.tick && !strobes.load |=> $stable(pos));
  p_wrap_up_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.tick && !strobes.load && dirNext && pos == POS_MAX |=> pos == '0);
  p_wrap_down_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.tick && !strobes.load && !dirNext && pos == '0 |=> pos == POS_MAX);
  p_flip_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.flipDir && !strobes.tick |=> stepCnt == '0);
  p_read_resp_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.reportPos |=> respValid && respCode == RESP_POS && respData == 32'($past(pos)));
  p_resp_cause_r10: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> $past(strobes.reportPos || strobes.reportCnt));
endmodule

// File: rtl/led_chaser_top.sv
module led_chaser_top
  import led_chaser_pkg::*;
#(
  parameter int NUM_LEDS = 8,
  parameter int CLK_HZ   = 50_000_000,
  parameter int CNT_W    = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                enSwitch,
  input  logic                revBtn,
  input  logic                reportBtn,
  input  logic                hostValid,
  input  logic [1:0]          hostOp,
  input  logic [31:0]         hostPos,
  output logic [NUM_LEDS-1:0] ledOut,
  output logic                respValid,
  output logic [31:0]         respCode,
  output logic [31:0]         respData
);
  localparam int POS_W = $clog2(NUM_LEDS);

  chaserStrobes_t strobes;

  led_chaser_ctrl #(.NUM_LEDS(NUM_LEDS), .CLK_HZ(CLK_HZ)) u_ctrl (
    .clk(clk), .rstN(rstN), .enSwitch(enSwitch), .revBtn(revBtn),
    .reportBtn(reportBtn), .hostValid(hostValid), .hostOp(hostOp),
    .hostPos(hostPos), .strobes(strobes));

  led_chaser_datapath #(.NUM_LEDS(NUM_LEDS), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .loadPos(hostPos[POS_W-1:0]),
    .ledOut(ledOut), .respValid(respValid), .respCode(respCode),
    .respData(respData));
endmodule

// File: tb/led_chaser_top_tb.sv
`timescale 1ns/1ps
module led_chaser_top_tb;
  localparam int HZ = 10;

  logic clk = 1'b0, rstN = 1'b0, enSwitch = 1'b0, revBtn = 1'b0, reportBtn = 1'b0;
  logic hostValid = 1'b0;
  logic [1:0] hostOp = 2'd3;
  logic [31:0] hostPos = '0;
  logic [7:0] ledOut;
  logic respValid;
  logic [31:0] respCode, respData;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  led_chaser_top #(.NUM_LEDS(8), .CLK_HZ(HZ)) u_dut (
    .clk(clk), .rstN(rstN), .enSwitch(enSwitch), .revBtn(revBtn),
    .reportBtn(reportBtn), .hostValid(hostValid), .hostOp(hostOp),
    .hostPos(hostPos), .ledOut(ledOut), .respValid(respValid),
    .respCode(respCode), .respData(respData));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // issue one host command; returns at the negedge where the response is visible
  task automatic host(input logic [1:0] op, input logic [31:0] p);
    @(negedge clk); hostValid = 1'b1; hostOp = op; hostPos = p;
    @(negedge clk); hostValid = 1'b0; hostOp = 2'd3;
  endtask

  task automatic pulse_rev();
    @(negedge clk); revBtn = 1'b1;
    @(negedge clk); revBtn = 1'b0;
  endtask

  task automatic report_count(input logic [31:0] exp, input string req);
    @(negedge clk); reportBtn = 1'b1;
    @(negedge clk); reportBtn = 1'b0;
    chk({req, " count valid"}, 32'(respValid), 1);
    chk({req, " count code"}, respCode, 32'd2);
    chk({req, " count value"}, respData, exp);
  endtask

  task automatic run_steps(input int n);
    @(negedge clk); enSwitch = 1'b1;
    repeat (n * HZ) @(posedge clk);
    @(negedge clk); enSwitch = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 led", 32'(ledOut), 32'h01);
    chk("R1 resp", 32'(respValid), 0);
    report_count(0, "R1");
  endtask

  task automatic t_step();
    @(negedge clk); enSwitch = 1'b1;
    repeat (HZ - 1) @(posedge clk);
    @(negedge clk); chk("R2 before tick", 32'(ledOut), 32'h01);
    @(negedge clk); chk("R2 one tick", 32'(ledOut), 32'h02);
    repeat (4) @(negedge clk);
    enSwitch = 1'b0;
    repeat (3) @(negedge clk);
    enSwitch = 1'b1;
    repeat (HZ - 1) @(posedge clk);
    @(negedge clk); chk("R2 prescaler restarted", 32'(ledOut), 32'h02);
    @(negedge clk); chk("R2 second tick", 32'(ledOut), 32'h04);
    enSwitch = 1'b0;
    repeat (HZ * 2) @(negedge clk);
    chk("R2 disabled holds", 32'(ledOut), 32'h04);
    report_count(2, "R9");
  endtask

  task automatic t_wrap();
    host(2'd1, 7);
    chk("R7 load 7", 32'(ledOut), 32'h80);
    run_steps(1);
    chk("R3 wrap up", 32'(ledOut), 32'h01);
    pulse_rev();
    report_count(0, "R5 button");
    run_steps(1);
    chk("R3 wrap down", 32'(ledOut), 32'h80);
    host(2'd2, 0);
    run_steps(1);
    chk("R5 host reverse", 32'(ledOut), 32'h01);
  endtask

  task automatic t_write_read();
    host(2'd1, 5);
    chk("R7 load 5", 32'(ledOut), 32'h20);
    host(2'd1, 9);
    chk("R7 ignore 9", 32'(ledOut), 32'h20);
    host(2'd1, 32'h0000_0108);
    chk("R7 ignore wide", 32'(ledOut), 32'h20);
    host(2'd0, 0);
    chk("R8 valid", 32'(respValid), 1);
    chk("R8 code", respCode, 32'd1);
    chk("R8 data", respData, 32'd5);
    @(negedge clk);
    chk("R8 single cycle", 32'(respValid), 0);
  endtask

  task automatic t_count();
    pulse_rev();
    pulse_rev();
    run_steps(3);
    chk("R4 after 3 up", 32'(ledOut), 32'h01);
    report_count(3, "R9 three steps");
    host(2'd1, 2);
    report_count(3, "R7 write no count");
  endtask

  task automatic t_collide();
    // pos 2, direction up; reversal on tick cycle
    @(negedge clk); enSwitch = 1'b1;
    repeat (HZ - 1) @(posedge clk);
    @(negedge clk); revBtn = 1'b1;
    @(negedge clk); revBtn = 1'b0; enSwitch = 1'b0;
    chk("R6 step uses new dir", 32'(ledOut), 32'h02);
    report_count(1, "R9 flip with step");
    @(negedge clk); reportBtn = 1'b1; hostValid = 1'b1; hostOp = 2'd0;
    @(negedge clk); reportBtn = 1'b0; hostValid = 1'b0; hostOp = 2'd3;
    chk("R10 read wins code", respCode, 32'd1);
    chk("R10 read wins data", respData, 32'd1);
  endtask

  task automatic t_nop();
    host(2'd3, 4);
    chk("R11 no response", 32'(respValid), 0);
    chk("R11 led kept", 32'(ledOut), 32'h02);
    report_count(1, "R11 count kept");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_step();
    t_wrap();
    t_write_read();
    t_count();
    t_collide();
    t_nop();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #500000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule